// File: doc/BRIEF.md
# Partial-Word Store Lane Mask Generator

This block accepts a request to store part of a register into memory and turns it into exactly one aligned memory write with a per-byte enable mask. Each request carries a byte address, a 64-bit data register, a mode select (head or tail) and a word-size select (32-bit or 64-bit). The block clears the low address bits to form the aligned word address. It places the data on big-endian byte lanes and computes which lanes are written. The result is presented as a single write beat. Stores of 3, 5, 6 or 7 bytes therefore reach memory as one masked write and are never split.

Head mode writes from the addressed byte to the end of the word, taking the low-order bytes of the register. Tail mode writes from the start of the word up to, but not including, the addressed byte, taking the high-order bytes of the register. A tail store at offset 0 writes nothing. It is still issued as a write beat with an empty mask and a probe flag set, so that the memory side can run its permission check and mark the line dirty. The request side and the write side each use a valid/ready handshake, with one registered stage between them.

Top module: `span_store_gen`

## Requirements
- R1: While reset is high and on the first cycle after it, `wr_valid` is 0, `wr_probe` is 0 and `req_ready` is 1.
- R2: A request is accepted on a clock edge where `req_valid` and `req_ready` are both 1. Its write beat appears with `wr_valid` = 1 after that edge. `req_ready` equals `!wr_valid || wr_ready`.
- R3: While `wr_valid` is 1 and `wr_ready` is 0, the outputs `wr_addr`, `wr_data`, `wr_be` and `wr_probe` stay unchanged, and any new request is not taken.
- R4: `wr_addr` is `req_addr` with the low 2 bits cleared when `req_wide` = 0, and with the low 3 bits cleared when `req_wide` = 1.
- R5: The offset k is `req_addr[1:0]` when `req_wide` = 0 and `req_addr[2:0]` when `req_wide` = 1, so address bit 2 does not change the mask for a 32-bit store. Memory is big-endian: word byte j maps to `wr_be[W-1-j]` and to `wr_data[8*(W-1-j) +: 8]`, where W is 4 or 8. In 32-bit mode, `wr_be[7:4]` and `wr_data[63:32]` are 0.
- R6: In head mode (`req_tail` = 0), the bytes at offsets k through W-1 are enabled. Offset 0 enables the full word.
- R7: In tail mode (`req_tail` = 1) with k > 0, the bytes at offsets 0 through k-1 are enabled.
- R8: Each enabled lane of `wr_data` carries the same bits of `req_data` (head mode therefore writes the low-order register bytes and tail mode the high-order ones). Each disabled lane is 0.
- R9: A tail-mode request with k = 0 produces a beat with `wr_be` = 0 and `wr_probe` = 1. Every other request gives `wr_probe` = 0 and a non-zero `wr_be`.
- R10: Each accepted request produces exactly one write beat, including 3-, 5-, 6- and 7-byte stores. Once the beat is taken by `wr_ready` and no new request is accepted, `wr_valid` drops on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_addr | input | ADDR_W | Byte address of the store |
| req_data | input | 64 | Source register |
| req_tail | input | 1 | 0 = head mode, 1 = tail mode |
| req_wide | input | 1 | 0 = 32-bit word, 1 = 64-bit word |
| wr_valid | output | 1 | Write beat present |
| wr_ready | input | 1 | Memory side takes the beat |
| wr_addr | output | ADDR_W | Aligned word address |
| wr_data | output | 64 | Data on big-endian lanes, disabled lanes zero |
| wr_be | output | 8 | Byte enables, bit 7 is byte offset 0 of a 64-bit word |
| wr_probe | output | 1 | Empty write: check access, store nothing |

## Verification
The bench sweeps every offset in both modes and both word sizes, with two data patterns and with address bit 2 toggled for 32-bit stores. The corner cases it targets are these:
- Tail mode at offset 0 must give an empty mask with the probe flag. A design that treated it as a full word would overwrite memory.
- Head mode at offset 0 must give the full word.
- 32-bit stores must ignore address bit 2. A design that used three offset bits would mask the wrong lanes.
- A lane-reversal mistake would put register bytes at the wrong end of the word.

Some requests are stalled on the write side while a competing request is offered. A design that updated its output register during the stall, or split an odd-length store into two beats, would change the held beat or leave `wr_valid` high after the hand-off.

// File: rtl/span_store_pkg.sv
package span_store_pkg;
    localparam int LANES  = 8;
    localparam int LANE_W = 8;
    localparam int BUS_W  = LANES * LANE_W;
    localparam int OFF_W  = $clog2(LANES);

    typedef enum logic {SPAN_HEAD = 1'b0, SPAN_TAIL = 1'b1} span_mode_e;
    typedef enum logic {WORD_NARROW = 1'b0, WORD_WIDE = 1'b1} word_size_e;

    typedef struct packed {
        logic [LANES-1:0] be;
        logic             probe;
        logic [BUS_W-1:0] data;
    } beat_body_t;

    // Lane numbering: lane 0 is the least significant byte of the bus.
    function automatic logic lane_on(int unsigned lane, word_size_e sz,
                                     span_mode_e md, logic [OFF_W-1:0] k);
        int unsigned span;
        int unsigned pos;
        span = (sz == WORD_WIDE) ? LANES : LANES / 2;
        if (lane >= span) return 1'b0;
        pos = span - 1 - lane;
        if (md == SPAN_HEAD) return pos >= 32'(k);
        return pos < 32'(k);
    endfunction

    function automatic logic [BUS_W-1:0] expand_lanes(logic [LANES-1:0] be);
        logic [BUS_W-1:0] m;
        for (int i = 0; i < LANES; i++) m[i*LANE_W +: LANE_W] = {LANE_W{be[i]}};
        return m;
    endfunction
endpackage

// File: rtl/span_lane_mask.sv
module span_lane_mask
    import span_store_pkg::*;
(
    input  word_size_e       sz,
    input  span_mode_e       md,
    input  logic [OFF_W-1:0] k,
    output logic [LANES-1:0] be,
    output logic             probe
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign be[g] = lane_on(g, sz, md, k);
    end

    assign probe = (md == SPAN_TAIL) && (k == '0);
endmodule

// File: rtl/span_lane_data.sv
module span_lane_data
    import span_store_pkg::*;
(
    input  logic [BUS_W-1:0] src,
    input  logic [LANES-1:0] be,
    output logic [BUS_W-1:0] dst
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign dst[g*LANE_W +: LANE_W] = be[g] ? src[g*LANE_W +: LANE_W] : '0;
    end
endmodule

// File: rtl/span_beat_hold.sv
module span_beat_hold
    import span_store_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [ADDR_W-1:0] in_addr,
    input  beat_body_t        in_body,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [ADDR_W-1:0] out_addr,
    output beat_body_t        out_body
);
    assign in_ready = !out_valid || out_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_addr  <= '0;
            out_body  <= '0;
        end else if (in_ready) begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_addr <= in_addr;
                out_body <= in_body;
            end
        end
    end
endmodule

// File: rtl/span_store_gen.sv
module span_store_gen
    import span_store_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [BUS_W-1:0]  req_data,
    input  logic              req_tail,
    input  logic              req_wide,
    output logic              wr_valid,
    input  logic              wr_ready,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [BUS_W-1:0]  wr_data,
    output logic [LANES-1:0]  wr_be,
    output logic              wr_probe
);
    localparam logic [ADDR_W-1:0] WIDE_LOW   = ADDR_W'(LANES - 1);
    localparam logic [ADDR_W-1:0] NARROW_LOW = ADDR_W'(LANES / 2 - 1);

    word_size_e        sz;
    span_mode_e        md;
    logic [OFF_W-1:0]  k;
    logic [ADDR_W-1:0] aligned;
    logic [LANES-1:0]  be_c;
    logic              probe_c;
    logic [BUS_W-1:0]  data_c;
    beat_body_t        body_c;
    beat_body_t        body_q;

    assign sz      = word_size_e'(req_wide);
    assign md      = span_mode_e'(req_tail);
    assign k       = (sz == WORD_WIDE) ? req_addr[OFF_W-1:0]
                                       : {1'b0, req_addr[OFF_W-2:0]};
    assign aligned = req_addr & ~((sz == WORD_WIDE) ? WIDE_LOW : NARROW_LOW);

    span_lane_mask u_mask (
        .sz    (sz),
        .md    (md),
        .k     (k),
        .be    (be_c),
        .probe (probe_c)
    );

    span_lane_data u_data (
        .src (req_data),
        .be  (be_c),
        .dst (data_c)
    );

    assign body_c = '{be: be_c, probe: probe_c, data: data_c};

    span_beat_hold #(.ADDR_W(ADDR_W)) u_hold (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (req_valid),
        .in_ready  (req_ready),
        .in_addr   (aligned),
        .in_body   (body_c),
        .out_valid (wr_valid),
        .out_ready (wr_ready),
        .out_addr  (wr_addr),
        .out_body  (body_q)
    );

    assign wr_data  = body_q.data;
    assign wr_be    = body_q.be;
    assign wr_probe = body_q.probe;
endmodule

// File: rtl/span_store_gen_chk.sv
module span_store_gen_chk
    import span_store_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_ready,
    input logic              wr_valid,
    input logic              wr_ready,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [BUS_W-1:0]  wr_data,
    input logic [LANES-1:0]  wr_be,
    input logic              wr_probe
);
    // R2
    idle_ready_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_valid |-> req_ready);

    // R3
    hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data)
                                     && $stable(wr_be) && $stable(wr_probe)));

    // R4
    aligned_addr_chk: assert property (@(posedge clk) disable iff (rst)
        wr_valid |-> (wr_addr[1:0] == 2'b00));

    // R8
    dead_lane_zero_chk: assert property (@(posedge clk) disable iff (rst)
        wr_valid |-> ((wr_data & ~expand_lanes(wr_be)) == '0));

    // R9
    probe_empty_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && wr_probe) |-> (wr_be == '0));

    // R9
    real_write_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && !wr_probe) |-> (wr_be != '0));

    // R10
    single_beat_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && wr_ready && !req_valid) |=> !wr_valid);
endmodule

bind span_store_gen span_store_gen_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .wr_valid  (wr_valid),
    .wr_ready  (wr_ready),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .wr_be     (wr_be),
    .wr_probe  (wr_probe)
);

// File: tb/span_store_gen_bench.sv
module span_store_gen_bench;
    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [AW-1:0] req_addr = '0;
    logic [63:0]   req_data = '0;
    logic          req_tail = 1'b0;
    logic          req_wide = 1'b0;
    logic          wr_valid;
    logic          wr_ready = 1'b0;
    logic [AW-1:0] wr_addr;
    logic [63:0]   wr_data;
    logic [7:0]    wr_be;
    logic          wr_probe;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    span_store_gen #(.ADDR_W(AW)) u_span_store_gen (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_data(req_data), .req_tail(req_tail),
        .req_wide(req_wide), .wr_valid(wr_valid), .wr_ready(wr_ready),
        .wr_addr(wr_addr), .wr_data(wr_data), .wr_be(wr_be), .wr_probe(wr_probe)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic run_req(input bit wide, input bit tail, input logic [AW-1:0] addr,
                           input logic [63:0] data, input bit stall);
        int          wb;
        int          k;
        logic [7:0]  e_be;
        logic [63:0] e_data;
        logic [AW-1:0] e_addr;
        bit          e_probe;
        wb = wide ? 8 : 4;
        k  = int'(addr) & (wb - 1);
        e_be = '0;
        e_data = '0;
        for (int j = 0; j < wb; j++) begin
            bit on;
            int lane;
            on   = tail ? (j < k) : (j >= k);
            lane = wb - 1 - j;
            if (on) begin
                e_be[lane] = 1'b1;
                e_data[lane*8 +: 8] = data[lane*8 +: 8];
            end
        end
        e_addr  = addr & ~AW'(wb - 1);
        e_probe = tail && (k == 0);

        @(negedge clk);
        req_wide = wide; req_tail = tail; req_addr = addr; req_data = data;
        req_valid = 1'b1; wr_ready = 1'b0;
        @(negedge clk);
        req_valid = 1'b0;
        chk(wr_valid === 1'b1, "R2 beat valid", 64'(wr_valid), 64'd1);
        chk(req_ready === 1'b0, "R2 ready low while held", 64'(req_ready), 64'd0);
        chk(wr_addr === e_addr, "R4 aligned addr", 64'(wr_addr), 64'(e_addr));
        chk(wr_be === e_be, tail ? "R7 R5 tail enables" : "R6 R5 head enables",
            64'(wr_be), 64'(e_be));
        chk(wr_data === e_data, "R8 lane data", wr_data, e_data);
        chk(wr_probe === e_probe, "R9 probe flag", 64'(wr_probe), 64'(e_probe));
        if (stall) begin
            req_wide = ~wide; req_tail = ~tail; req_addr = ~addr; req_data = ~data;
            req_valid = 1'b1;
            @(negedge clk);
            req_valid = 1'b0;
            chk(wr_valid === 1'b1 && wr_be === e_be && wr_data === e_data &&
                wr_addr === e_addr && wr_probe === e_probe,
                "R3 held during stall", wr_data, e_data);
        end
        wr_ready = 1'b1;
        @(negedge clk);
        wr_ready = 1'b0;
        chk(wr_valid === 1'b0, "R10 one beat per request", 64'(wr_valid), 64'd0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(wr_valid === 1'b0 && wr_probe === 1'b0, "R1 reset outputs",
            {62'd0, wr_valid, wr_probe}, 64'd0);
        rst = 1'b0;
        @(negedge clk);
        chk(wr_valid === 1'b0 && req_ready === 1'b1, "R1 after reset",
            {62'd0, wr_valid, req_ready}, 64'd1);
        for (int w = 0; w < 2; w++) begin
            for (int t = 0; t < 2; t++) begin
                for (int o = 0; o < 8; o++) begin
                    for (int p = 0; p < 2; p++) begin
                        logic [63:0] d;
                        logic [AW-1:0] a;
                        d = p ? 64'hF0E1_D2C3_B4A5_9687 : 64'h0123_4567_89AB_CDEF;
                        a = 32'h8A50_0000 | AW'((w * 64 + t * 32 + o * 2 + p) << 4) | AW'(o);
                        run_req(w[0], t[0], a, d, p[0] ^ o[0]);
                    end
                end
            end
        end
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=%h expected=%h", 64'd0, 64'd1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end
endmodule